// File: doc/BRIEF.md
# Burst Address Sequencer

This block drives the address and transfer-type outputs of a pipelined bus master for one burst at a time. A burst starts with a one-cycle start pulse that carries a byte start address, a size code and a burst code. The block then issues one address per beat, together with a transfer-type code and a flag that marks the final beat. It moves to the next beat only in a cycle where the bus ready input is high. A ready input held low freezes every output.

The block supports single transfers, incrementing bursts of 4, 8 or 16 beats, wrapping bursts of 4, 8 or 16 beats, and incrementing bursts of open length that run until a stop request. On request it inserts pause (BUSY) cycles between beats. It rejects a start address that is not aligned to the beat size: it raises an error flag and starts nothing.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `trans_o` is IDLE (2'b00), `addr_o` is 0, and `last_o` and `err_o` are 0.
- R2: The block accepts a start only when it is idle and both `start_i` and `ready_i` are high. The cycle after an accepted start shows NONSEQ (2'b10) with `addr_o` equal to the start address. A start request while `ready_i` is low is not accepted.
- R3: In an incrementing burst (burst codes 1, 3, 5, 7), each beat after the first is SEQ (2'b11) and carries the previous address plus 2^`size_i` bytes. The addition is modulo 2^32.
- R4: In a wrapping burst (codes 2=4 beats, 4=8 beats, 6=16 beats), the next address is the previous address plus 2^size. The sum is taken modulo the span, where the span is 2^size times the beat count. All address bits above the span stay unchanged.
- R5: Code 0 issues exactly 1 beat. Codes 2 and 3 issue 4 beats, codes 4 and 5 issue 8 beats, and codes 6 and 7 issue 16 beats. `last_o` is high on the final beat only. The cycle after that beat completes returns to IDLE.
- R6: While `ready_i` is low during a burst, `addr_o`, `trans_o` and `last_o` hold their values.
- R7: If `busy_req_i` is high when a beat completes, the next cycle is BUSY (2'b01). That cycle already carries the next beat's address, has `last_o` low and does not count as a beat. When `busy_req_i` drops, a SEQ beat follows at the same address.
- R8: An open-length burst (code 1) keeps issuing beats with `last_o` low. It ends when `stop_i` is high as a NONSEQ or SEQ beat completes, and the following cycle is IDLE.
- R9: A start whose address is not a multiple of 2^size raises `err_o` for exactly one cycle, and `trans_o` stays IDLE.
- R10: A `start_i` pulse that arrives while a burst is in progress has no effect on the burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a burst |
| start_addr_i | input | 32 | Byte address of the first beat |
| size_i | input | 3 | Beat size code; bytes per beat = 2^size_i |
| burst_i | input | 3 | Burst kind and length code |
| ready_i | input | 1 | Bus ready; the current phase completes when high |
| busy_req_i | input | 1 | Request a pause cycle before the next beat |
| stop_i | input | 1 | Ends an open-length burst after the current beat |
| addr_o | output | 32 | Address of the current phase |
| trans_o | output | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| last_o | output | 1 | High on the final beat of a fixed-length burst |
| err_o | output | 1 | One-cycle flag for a misaligned start |

## Verification
A wrong beat count shows at the ports in the same cycle as the burst boundary. A fixed burst that is one beat short or one beat long either raises `last_o` on the wrong beat or leaves IDLE visible one cycle too early or too late. A wrong folding mask in a wrapping burst appears on the first beat that crosses the span boundary, and the bench places that crossing inside several wrap vectors. A counter that moves during a pause shows up as `last_o` firing one SEQ beat early after a BUSY cycle. A stall that leaks changes `addr_o` while `ready_i` is low, and the bench and a bound property both watch for that in the very next cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int ADDR_W    = 32;
    localparam int SIZE_W    = 3;
    localparam int BURST_W   = 3;
    localparam int MAX_BEATS = 16;
    localparam int CNT_W     = $clog2(MAX_BEATS);

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [BURST_W-1:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        trans_e            trans;
    } phase_t;

    // number of beats; zero marks an open-length burst
    function automatic logic [CNT_W:0] beat_total(burst_e b);
        case (b)
            BT_SINGLE:           return (CNT_W+1)'(1);
            BT_WRAP4,  BT_INCR4:  return (CNT_W+1)'(4);
            BT_WRAP8,  BT_INCR8:  return (CNT_W+1)'(8);
            BT_WRAP16, BT_INCR16: return (CNT_W+1)'(16);
            default:             return '0;
        endcase
    endfunction

    // log2 of the beat count of a wrapping burst
    function automatic logic [2:0] wrap_log2(burst_e b);
        case (b)
            BT_WRAP4:  return 3'd2;
            BT_WRAP8:  return 3'd3;
            BT_WRAP16: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    function automatic logic is_wrap(burst_e b);
        return (b == BT_WRAP4) || (b == BT_WRAP8) || (b == BT_WRAP16);
    endfunction
endpackage

// File: rtl/bag_addr_step.sv
module bag_addr_step
    import bag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  burst_e            burst_i,
    output logic [AW-1:0]     next_o
);
    localparam int SHW = $clog2(AW);

    logic [AW-1:0]  bytes;
    logic [AW-1:0]  span_mask;
    logic [AW-1:0]  sum;
    logic [SHW-1:0] span_sh;

    always_comb begin
        bytes     = AW'(1) << size_i;
        span_sh   = SHW'(size_i) + SHW'(wrap_log2(burst_i));
        span_mask = (AW'(1) << span_sh) - AW'(1);
        sum       = addr_i + bytes;
        if (is_wrap(burst_i))
            next_o = (addr_i & ~span_mask) | (sum & span_mask);
        else
            next_o = sum;
    end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import bag_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  logic        adv_i,
    input  logic [CW:0] total_i,
    output logic        final_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (adv_i)
            cnt_q <= cnt_q + CW'(1);
    end

    assign final_o = (total_i != '0) && ({1'b0, cnt_q} == total_i - (CW+1)'(1));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   start_addr_i,
    input  logic [SIZE_W-1:0]   size_i,
    input  logic [BURST_W-1:0]  burst_i,
    input  logic                ready_i,
    input  logic                busy_req_i,
    input  logic                stop_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [1:0]          trans_o,
    output logic                last_o,
    output logic                err_o
);
    phase_t            ph_q, ph_d;
    burst_e            burst_q, burst_d;
    logic [SIZE_W-1:0] size_q, size_d;
    logic              err_d, err_q;
    logic              clear, adv, final_beat, real_beat, aligned;
    logic [ADDR_W-1:0] step_addr;

    bag_addr_step #(.AW(ADDR_W)) step_i (
        .addr_i  (ph_q.addr),
        .size_i  (size_q),
        .burst_i (burst_q),
        .next_o  (step_addr)
    );

    bag_beat_ctr #(.CW(CNT_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .adv_i   (adv),
        .total_i (beat_total(burst_q)),
        .final_o (final_beat)
    );

    assign real_beat = (ph_q.trans == TR_NONSEQ) || (ph_q.trans == TR_SEQ);
    assign aligned   = (start_addr_i & ((ADDR_W'(1) << size_i) - ADDR_W'(1))) == '0;

    always_comb begin
        ph_d    = ph_q;
        burst_d = burst_q;
        size_d  = size_q;
        err_d   = 1'b0;
        clear   = 1'b0;
        adv     = 1'b0;
        if (ready_i) begin
            case (ph_q.trans)
                TR_IDLE: begin
                    if (start_i) begin
                        if (aligned) begin
                            ph_d.trans = TR_NONSEQ;
                            ph_d.addr  = start_addr_i;
                            burst_d    = burst_e'(burst_i);
                            size_d     = size_i;
                            clear      = 1'b1;
                        end else begin
                            err_d = 1'b1;
                        end
                    end
                end
                TR_NONSEQ, TR_SEQ: begin
                    if (final_beat || (burst_q == BT_INCR && stop_i)) begin
                        ph_d.trans = TR_IDLE;
                    end else begin
                        adv        = 1'b1;
                        ph_d.addr  = step_addr;
                        ph_d.trans = busy_req_i ? TR_BUSY : TR_SEQ;
                    end
                end
                default: begin
                    ph_d.trans = busy_req_i ? TR_BUSY : TR_SEQ;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= '{addr: '0, trans: TR_IDLE};
            burst_q <= BT_SINGLE;
            size_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            burst_q <= burst_d;
            size_q  <= size_d;
            err_q   <= err_d;
        end
    end

    assign addr_o  = ph_q.addr;
    assign trans_o = ph_q.trans;
    assign last_o  = real_beat && final_beat;
    assign err_o   = err_q;
endmodule

// File: rtl/bag_chk.sv
module bag_chk
    import bag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ready_i,
    input logic              stop_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        trans_o,
    input logic              last_o,
    input logic              err_o
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready_i && trans_o != 2'b00) |=> ($stable(addr_o) && $stable(trans_o) && $stable(last_o)));

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (trans_o == 2'b00) |=> (trans_o == 2'b00 || trans_o == 2'b10));

    // R7
    busy_not_last_chk: assert property (@(posedge clk) disable iff (rst)
        (trans_o == 2'b01) |-> !last_o);

    // R7
    busy_addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (trans_o == 2'b01 && ready_i) |=> ($stable(addr_o) && (trans_o == 2'b01 || trans_o == 2'b11)));

    // R5
    last_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> (trans_o == 2'b10 || trans_o == 2'b11));

    // R5
    last_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && ready_i) |=> (trans_o == 2'b00));

    // R3
    beat_continue_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_i && !stop_i && !last_o && (trans_o == 2'b10 || trans_o == 2'b11))
        |=> (trans_o == 2'b11 || trans_o == 2'b01));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (trans_o == 2'b00));
endmodule

bind burst_addr_gen bag_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .ready_i (ready_i),
    .stop_i  (stop_i),
    .addr_o  (addr_o),
    .trans_o (trans_o),
    .last_o  (last_o),
    .err_o   (err_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, ready_i, busy_req_i, stop_i;
    logic [31:0] start_addr_i;
    logic [2:0]  size_i, burst_i;
    logic [31:0] addr_o;
    logic [1:0]  trans_o;
    logic        last_o, err_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .size_i(size_i), .burst_i(burst_i), .ready_i(ready_i),
        .busy_req_i(busy_req_i), .stop_i(stop_i), .addr_o(addr_o),
        .trans_o(trans_o), .last_o(last_o), .err_o(err_o)
    );

    // {start address, size code, burst code}
    localparam int NV = 9;
    localparam logic [37:0] VEC [NV] = '{
        {32'h0000_0100, 3'd2, 3'd3},
        {32'h0000_0038, 3'd2, 3'd2},
        {32'h1000_0034, 3'd1, 3'd4},
        {32'h0000_0078, 3'd3, 3'd6},
        {32'hFFFF_FFF8, 3'd2, 3'd3},
        {32'h0000_0020, 3'd0, 3'd0},
        {32'h0000_0040, 3'd0, 3'd5},
        {32'h0000_0200, 3'd4, 3'd7},
        {32'h0000_03F0, 3'd2, 3'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] tr, input logic [31:0] a, input logic l);
        chk({req, " trans"}, {30'd0, trans_o}, {30'd0, tr});
        chk({req, " addr"}, addr_o, a);
        chk({req, " last"}, {31'd0, last_o}, {31'd0, l});
    endtask

    function automatic int beats_of(input logic [2:0] b);
        case (b)
            3'd0: return 1;
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            3'd6, 3'd7: return 16;
            default: return 0;
        endcase
    endfunction

    // independent reference: modulo arithmetic on the span
    function automatic logic [31:0] ref_next(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] b);
        logic [31:0] bytes, span, base;
        bytes = 32'd1 << sz;
        if (b == 3'd2 || b == 3'd4 || b == 3'd6) begin
            span = bytes * beats_of(b);
            base = a - (a % span);
            return base + ((a - base + bytes) % span);
        end
        return a + bytes;
    endfunction

    task automatic launch(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] b);
        start_i = 1'b1; start_addr_i = a; size_i = sz; burst_i = b; ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 0; start_addr_i = 0; size_i = 0; burst_i = 0;
        ready_i = 1'b1; busy_req_i = 0; stop_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_out("R1", 2'b00, 32'h0, 1'b0);
        chk("R1 err", {31'd0, err_o}, 32'd0);

        // R3 R4 R5 table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] a;
            logic [2:0]  sz, b;
            int n;
            {a, sz, b} = VEC[v];
            n = beats_of(b);
            launch(a, sz, b);
            for (int k = 0; k < n; k++) begin
                chk_out(b[0] || b == 3'd0 ? "R3/R5" : "R4/R5",
                        k == 0 ? 2'b10 : 2'b11, a, k == n - 1);
                a = ref_next(a, sz, b);
                @(negedge clk);
            end
            chk("R5 idle after burst", {30'd0, trans_o}, 32'd0);
        end

        // R2: start with ready low is not taken
        start_i = 1'b1; start_addr_i = 32'h40; size_i = 3'd2; burst_i = 3'd3; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; ready_i = 1'b1;
        chk("R2 no start while not ready", {30'd0, trans_o}, 32'd0);

        // R6 stall mid burst
        launch(32'h10, 3'd2, 3'd3);
        chk_out("R2 first beat", 2'b10, 32'h10, 1'b0);
        ready_i = 1'b0;
        @(negedge clk);
        chk_out("R6 hold", 2'b10, 32'h10, 1'b0);
        @(negedge clk);
        chk_out("R6 hold", 2'b10, 32'h10, 1'b0);
        ready_i = 1'b1;
        @(negedge clk);
        chk_out("R6 resume", 2'b11, 32'h14, 1'b0);
        // R10 start during a burst is ignored
        start_i = 1'b1; start_addr_i = 32'h800;
        @(negedge clk);
        start_i = 1'b0;
        chk_out("R10 ignore start", 2'b11, 32'h18, 1'b0);
        @(negedge clk);
        chk_out("R10 last beat", 2'b11, 32'h1C, 1'b1);
        @(negedge clk);
        chk("R10 idle", {30'd0, trans_o}, 32'd0);

        // R7 busy insertion
        launch(32'h0, 3'd2, 3'd3);
        busy_req_i = 1'b1;
        @(negedge clk);
        chk_out("R7 busy", 2'b01, 32'h4, 1'b0);
        @(negedge clk);
        chk_out("R7 busy again", 2'b01, 32'h4, 1'b0);
        busy_req_i = 1'b0;
        @(negedge clk);
        chk_out("R7 seq after busy", 2'b11, 32'h4, 1'b0);
        @(negedge clk);
        chk_out("R7 count held", 2'b11, 32'h8, 1'b0);
        @(negedge clk);
        chk_out("R7 last", 2'b11, 32'hC, 1'b1);
        @(negedge clk);
        chk("R7 idle", {30'd0, trans_o}, 32'd0);

        // R8 open-length burst
        launch(32'h80, 3'd2, 3'd1);
        for (int k = 0; k < 20; k++) begin
            chk_out("R8 open beat", k == 0 ? 2'b10 : 2'b11, 32'h80 + 32'(4 * k), 1'b0);
            if (k == 19) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk("R8 stop to idle", {30'd0, trans_o}, 32'd0);

        // R9 misaligned start
        launch(32'h102, 3'd2, 3'd3);
        chk("R9 err", {31'd0, err_o}, 32'd1);
        chk("R9 stays idle", {30'd0, trans_o}, 32'd0);
        @(negedge clk);
        chk("R9 err one cycle", {31'd0, err_o}, 32'd0);
        chk("R9 still idle", {30'd0, trans_o}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule